// File: doc/BRIEF.md
# Comparator edge-detect interrupt controller

This block is the digital side of an analog voltage comparator. The comparator output arrives without any relation to the bus clock. A chain of flops brings it into the clock domain, and a further registered stage compares consecutive samples to find transitions. A two-bit mode field chooses which transitions count: falling, rising, or either. A matching transition sets a sticky flag, and that flag drives the interrupt request. Software negates the flag with a handshake on a dedicated clear bit. It writes the bit to one and then writes it back to zero.

One 32-bit control word holds the rest of the settings. Other modules can take the comparator result either straight from the analog pin or as the synchronized copy. The positive-input code, the negative-input code and the hysteresis code are stored here and driven out to the analog front end. A read also returns the live synchronized comparator level. Register writes take effect on the clock edge when the write strobe is high. Reads are combinational.

Top module: `cmp_edge_ctl`

## Requirements
- R1: After reset, rd_data reads 0, irq is 0, cmp_to_mod follows cmp_raw, and pos_sel, neg_sel and hyst_code are 0.
- R2: Edge mode sits in bits 4:3. Code 0 counts falling transitions, code 1 counts rising ones, and codes 2 and 3 both count either direction. A counted transition of cmp_raw sets flag bit 23 and irq. Counting from the clock edge that first samples the new level, the flag appears after SYNC_STAGES+1 clock edges.
- R3: Once set, the flag and irq stay high until the clear handshake removes them. Further transitions and unrelated writes do not affect them.
- R4: Bit 20 is the clear bit. Two conditions force the flag to 0 and discard transitions: the clock edge of a write that sets bit 20 to 1, and every edge while bit 20 reads 1. Counting resumes on the first clock edge after the edge that writes bit 20 back to 0.
- R5: Bit 6 selects cmp_to_mod. When it is 0, cmp_to_mod is cmp_raw with no clocking. When it is 1, cmp_to_mod is the synchronized level, which lags cmp_raw by SYNC_STAGES clock edges.
- R6: Bit 21 reads the synchronized comparator level at all times.
- R7: Bits 10:8 hold the positive-input code and bits 13:11 hold the negative-input code. Each is driven on pos_sel or neg_sel. A write that carries code 7, which is reserved, leaves that field unchanged. The other fields of the same write are still applied.
- R8: Bits 26:25 hold the hysteresis code (0 none, 1 5 mV, 2 10 mV, 3 20 mV). The code is stored as written and driven on hyst_code.
- R9: Bits 21 and 23 ignore written data. Every bit outside 3, 4, 6, 8 to 13, 20, 21, 23, 25 and 26 reads 0.
- R10: A write updates the writable fields on the clock edge when wr_en is high. With wr_en low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data, combinational |
| cmp_raw | input | 1 | Asynchronous comparator output |
| irq | output | 1 | Edge interrupt request |
| cmp_to_mod | output | 1 | Comparator result for other modules |
| pos_sel | output | 3 | Positive-input code to the analog mux |
| neg_sel | output | 3 | Negative-input code to the analog mux |
| hyst_code | output | 2 | Hysteresis code to the analog block |

## Verification
The bench uses the default SYNC_STAGES of 2, which gives a three-edge path from cmp_raw to the flag. At that latency, random toggling of cmp_raw every cycle produces transitions spaced at every distance, including back-to-back reversals. It also puts clear writes on every clock phase relative to an in-flight transition. Random writes include the reserved select code and set the read-only bits, and the bench's cycle model predicts every field.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int REG_W = 32;

  localparam int MODE_LO = 3;
  localparam int OSEL_B  = 6;
  localparam int POS_LO  = 8;
  localparam int NEG_LO  = 11;
  localparam int CLR_B   = 20;
  localparam int STAT_B  = 21;
  localparam int FLAG_B  = 23;
  localparam int HYS_LO  = 25;

  localparam int SEL_W   = 3;
  localparam int HYS_W   = 2;
  localparam int MODE_W  = 2;

  localparam logic [SEL_W-1:0] SEL_RESERVED = 3'd7;
  localparam logic [REG_W-1:0] LIVE_MASK    = 32'h06B0_3F58;

  typedef enum logic [MODE_W-1:0] {
    EDG_FALL   = 2'd0,
    EDG_RISE   = 2'd1,
    EDG_BOTH_A = 2'd2,
    EDG_BOTH_B = 2'd3
  } edge_mode_e;

  typedef struct packed {
    edge_mode_e       mode;
    logic             osel;
    logic [SEL_W-1:0] pos;
    logic [SEL_W-1:0] neg;
    logic             clr;
    logic [HYS_W-1:0] hys;
  } ctl_fields_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= 1'b0;
    else        stage_q[0] <= d_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= 1'b0;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/cmp_edge_det.sv
module cmp_edge_det
  import cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  edge_mode_e mode,
  input  logic       block,
  output logic       flag
);
  logic prev_q;
  logic flag_q, flag_d;
  logic rise, fall, hit;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    unique case (mode)
      EDG_FALL:   hit = fall;
      EDG_RISE:   hit = rise;
      EDG_BOTH_A,
      EDG_BOTH_B: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
    if (block) flag_d = 1'b0;
    else       flag_d = flag_q | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/cmp_ctl_regs.sv
module cmp_ctl_regs
  import cmp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             status,
  input  logic             flag,
  output ctl_fields_t      fields,
  output logic             clr_block,
  output logic [REG_W-1:0] rd_data
);
  ctl_fields_t      f_q, f_d;
  logic [SEL_W-1:0] pos_w, neg_w;
  logic             unused_wr;

  assign pos_w = wr_data[POS_LO +: SEL_W];
  assign neg_w = wr_data[NEG_LO +: SEL_W];
  assign unused_wr = ^(wr_data & ~LIVE_MASK) ^ wr_data[STAT_B] ^ wr_data[FLAG_B];

  always_comb begin
    f_d = f_q;
    if (wr_en) begin
      f_d.mode = edge_mode_e'(wr_data[MODE_LO +: MODE_W]);
      f_d.osel = wr_data[OSEL_B];
      if (pos_w != SEL_RESERVED) f_d.pos = pos_w;
      if (neg_w != SEL_RESERVED) f_d.neg = neg_w;
      f_d.clr  = wr_data[CLR_B];
      f_d.hys  = wr_data[HYS_LO +: HYS_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  assign clr_block = f_q.clr | (wr_en & wr_data[CLR_B]);
  assign fields    = f_q;

  always_comb begin
    rd_data = '0;
    rd_data[MODE_LO +: MODE_W] = f_q.mode;
    rd_data[OSEL_B]            = f_q.osel;
    rd_data[POS_LO +: SEL_W]   = f_q.pos;
    rd_data[NEG_LO +: SEL_W]   = f_q.neg;
    rd_data[CLR_B]             = f_q.clr;
    rd_data[STAT_B]            = status;
    rd_data[FLAG_B]            = flag;
    rd_data[HYS_LO +: HYS_W]   = f_q.hys;
  end
endmodule

// File: rtl/cmp_edge_ctl.sv
module cmp_edge_ctl
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             cmp_raw,
  output logic             irq,
  output logic             cmp_to_mod,
  output logic [SEL_W-1:0] pos_sel,
  output logic [SEL_W-1:0] neg_sel,
  output logic [HYS_W-1:0] hyst_code
);
  logic [1:0]  rst_q;
  logic        rst_int_n;
  logic        lvl_sync;
  logic        flag;
  logic        clr_block;
  ctl_fields_t fields;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .d_async(cmp_raw),
    .q_sync (lvl_sync)
  );

  cmp_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_int_n),
    .lvl  (lvl_sync),
    .mode (fields.mode),
    .block(clr_block),
    .flag (flag)
  );

  cmp_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .status   (lvl_sync),
    .flag     (flag),
    .fields   (fields),
    .clr_block(clr_block),
    .rd_data  (rd_data)
  );

  assign irq        = flag;
  assign cmp_to_mod = fields.osel ? lvl_sync : cmp_raw;
  assign pos_sel    = fields.pos;
  assign neg_sel    = fields.neg;
  assign hyst_code  = fields.hys;
endmodule

// File: rtl/cmp_edge_ctl_chk.sv
module cmp_edge_ctl_chk
  import cmp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             irq,
  input logic             cmp_to_mod,
  input logic [SEL_W-1:0] pos_sel,
  input logic [SEL_W-1:0] neg_sel,
  input logic [HYS_W-1:0] hyst_code
);
  AST_IRQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(rd_data[STAT_B]) != $past(rd_data[STAT_B], 2))); // R2
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_data[CLR_B] && !(wr_en && wr_data[CLR_B])) |=> irq); // R3
  AST_CLR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CLR_B] |-> !irq); // R4
  AST_SYNC_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[OSEL_B] |-> (cmp_to_mod == rd_data[STAT_B])); // R5
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_sel != SEL_RESERVED) && (neg_sel != SEL_RESERVED)); // R7
  AST_HYS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (hyst_code == $past(wr_data[HYS_LO +: HYS_W]))); // R8
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE_MASK) == '0); // R9
endmodule

bind cmp_edge_ctl cmp_edge_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .irq       (irq),
  .cmp_to_mod(cmp_to_mod),
  .pos_sel   (pos_sel),
  .neg_sel   (neg_sel),
  .hyst_code (hyst_code)
);

// File: tb/sim_cmp_edge_ctl.sv
`timescale 1ns/1ps
module sim_cmp_edge_ctl;
  localparam int N = 2;
  localparam int CYC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        cmp_raw = 1'b0;
  logic [31:0] rd_data;
  logic        irq, cmp_to_mod;
  logic [2:0]  pos_sel, neg_sel;
  logic [1:0]  hyst_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CYC/2) clk = ~clk;

  cmp_edge_ctl #(.SYNC_STAGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cmp_raw(cmp_raw), .irq(irq), .cmp_to_mod(cmp_to_mod),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .hyst_code(hyst_code)
  );

  // cycle model built from the requirements
  logic [N-1:0] m_sync;
  logic m_prev, m_flag, m_osel, m_clr;
  logic [1:0] m_mode, m_hys;
  logic [2:0] m_pos, m_neg;

  always @(posedge clk or negedge rst_n) begin
    logic lv, hit, blk;
    if (!rst_n) begin
      m_sync = '0; m_prev = 0; m_flag = 0; m_osel = 0; m_clr = 0;
      m_mode = 0; m_hys = 0; m_pos = 0; m_neg = 0;
    end else begin
      lv  = m_sync[N-1];
      blk = m_clr | (wr_en & wr_data[20]);
      case (m_mode)
        2'd0:    hit = !lv && m_prev;
        2'd1:    hit = lv && !m_prev;
        default: hit = lv != m_prev;
      endcase
      m_flag = blk ? 1'b0 : (m_flag | hit);
      m_prev = lv;
      m_sync = {m_sync[N-2:0], cmp_raw};
      if (wr_en) begin
        m_mode = wr_data[4:3];
        m_osel = wr_data[6];
        if (wr_data[10:8] != 3'd7) m_pos = wr_data[10:8];
        if (wr_data[13:11] != 3'd7) m_neg = wr_data[13:11];
        m_clr = wr_data[20];
        m_hys = wr_data[26:25];
      end
    end
  end

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    r[4:3] = m_mode; r[6] = m_osel; r[10:8] = m_pos; r[13:11] = m_neg;
    r[20] = m_clr; r[21] = m_sync[N-1]; r[23] = m_flag; r[26:25] = m_hys;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_model();
    logic [31:0] e = exp_rd();
    chk("R2 edge mode/flag", {31'd0, rd_data[23]}, {31'd0, e[23]});
    chk("R3 irq", {31'd0, irq}, {31'd0, m_flag});
    chk("R6 status", {31'd0, rd_data[21]}, {31'd0, e[21]});
    chk("R10 fields", rd_data & 32'h0010_0058, e & 32'h0010_0058);
    chk("R7 sel", {26'd0, pos_sel, neg_sel}, {26'd0, m_pos, m_neg});
    chk("R8 hys", {30'd0, hyst_code}, {30'd0, m_hys});
    chk("R9 unused", rd_data & ~32'h06B0_3F58, 32'd0);
    chk("R5 out", {31'd0, cmp_to_mod}, {31'd0, m_osel ? m_sync[N-1] : cmp_raw});
  endtask

  task automatic wr(input logic [31:0] d);
    wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CYC * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    rst_n = 1'b1;
    idle(5);
    // R1 reset state
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 outputs", {24'd0, pos_sel, neg_sel, hyst_code}, 32'd0);

    // R5 direct path is unclocked
    cmp_raw = 1'b1; #1;
    chk("R5 direct", {31'd0, cmp_to_mod}, 32'd1);
    // R1 default falling mode: a rise does not flag
    idle(N + 2);
    chk("R1 falling default", {31'd0, irq}, 32'd0);
    cmp_raw = 1'b0;
    idle(N + 1);
    chk("R2 fall latency", {31'd0, irq}, 32'd1);

    // R4 clear handshake with an edge during clear
    wr(32'h0010_0008);          // rise mode, clear=1
    chk("R4 clear forces 0", {31'd0, irq}, 32'd0);
    cmp_raw = 1'b1;
    idle(N + 3);
    chk("R4 edge ignored", {31'd0, irq}, 32'd0);
    wr(32'h0000_0008);
    idle(2);
    chk("R4 stays low after release", {31'd0, irq}, 32'd0);

    // R7 reserved code keeps old value; R9 read-only bits
    wr(32'h0000_1A08);          // pos=2 neg=3
    wr(32'h00A0_3F08);          // pos=7 neg=7, sets bits 21/23 in data
    chk("R7 reserved ignored", {26'd0, pos_sel, neg_sel}, {26'd0, 3'd2, 3'd3});
    chk("R9 ro bit 23", {31'd0, rd_data[23]}, 32'd0);
    chk("R9 ro bit 21", {31'd0, rd_data[21]}, 32'd1);

    // R2 both-edge codes 2 and 3
    wr(32'h0000_0010);
    cmp_raw = 1'b0; idle(N + 1);
    chk("R2 code 2 fall", {31'd0, irq}, 32'd1);
    wr(32'h0010_0018); wr(32'h0000_0018);
    cmp_raw = 1'b1; idle(N + 1);
    chk("R2 code 3 rise", {31'd0, irq}, 32'd1);

    // random phase, checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      check_model();
      if ($urandom_range(3) == 0) cmp_raw = ~cmp_raw;
      if ($urandom_range(7) == 0) begin
        logic [31:0] d = $urandom();
        d[20] = ($urandom_range(3) == 0);
        wr_data = d; wr_en = 1'b1;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    check_model();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule